// File: doc/BRIEF.md
# SPI Status Flags and Slave-Select Driver

This block keeps the two sticky event flags of a byte-wide SPI peripheral and drives the slave-select pin of its master side. It watches a shift engine through two plain signals: a one-cycle pulse when a byte has finished and a level that is high while a byte is moving. A CPU register interface reaches the block through separate read and write strobes, one pair for the status register and one pair for the data register. A software slave-select value from elsewhere in the peripheral feeds the pin logic.

The flags cannot be cleared by writing them. Software clears them with a two-step handshake. It first reads the status register while a flag is up, which arms the block and records which flags were seen. It then reads or writes the data register, and the recorded flags drop. If the data register is written while a byte is still moving, the write is refused: the stored byte and the engine are left alone, and the collision flag rises. The interrupt request is high whenever either flag is high.

The control and status pins are plain level or strobe signals, with no handshake. Every register strobe is taken in the cycle it is high. A status read returns data in the same cycle, combinationally.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, the data register reads 0, `irq_o` and `tx_load_o` are low, and `nss_o` is high.
- R2: Status register layout: bit 7 is the completion flag, bit 6 is the collision flag, bits 5..1 read 0, and bit 0 is the slave-select control enable. A status write changes only bit 0 and ignores bits 7..1 of the written byte.
- R3: A `xfer_done_i` pulse sets the completion flag, and the flag is visible from the next cycle.
- R4: A data write while `xfer_busy_i` is high sets the collision flag on the next cycle. The write is dropped: the data register keeps its old value and `tx_load_o` stays low.
- R5: A data write while `xfer_busy_i` is low stores the byte, and the byte is readable from the next cycle. It also raises `tx_load_o` for exactly that next cycle, with `tx_byte_o` holding the byte.
- R6: A status read taken while at least one flag is set arms the clear. The next data read or data write then clears the flags that were set at that read. A data access without a prior arming read clears nothing.
- R7: A flag that rises after the arming read is not cleared by the following data access. One data access disarms, so a second access without a new status read clears nothing.
- R8: When a flag's set event and its clear land in the same cycle, the flag stays set.
- R9: `irq_o` is high exactly when the completion flag or the collision flag is high.
- R10: With the enable bit at 1, `nss_o` is high when `xfer_busy_i` is low and equals `sw_sel_i` when it is high. The pin is registered and reflects its inputs one cycle later.
- R11: With the enable bit at 0, `nss_o` equals `sw_sel_i` from the previous cycle, whatever the busy level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_done_i | input | 1 | One-cycle pulse from the shift engine at the end of a byte |
| xfer_busy_i | input | 1 | High while the shift engine is moving a byte |
| sw_sel_i | input | 1 | Software slave-select level |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 8 | Status write data; only bit 0 is used |
| stat_rdata_o | output | 8 | Status register contents |
| data_rd_i | input | 1 | Data register read strobe |
| data_wr_i | input | 1 | Data register write strobe |
| data_wdata_i | input | DATA_W | Data register write byte |
| data_rdata_o | output | DATA_W | Data register contents |
| tx_load_o | output | 1 | One-cycle pulse telling the engine to take a new byte |
| tx_byte_o | output | DATA_W | Byte offered to the engine |
| done_flag_o | output | 1 | Completion flag |
| wcol_flag_o | output | 1 | Collision flag |
| irq_o | output | 1 | Interrupt request |
| nss_o | output | 1 | Slave-select pin level |

## Verification
The clear handshake is swept over all four starting flag pairs. Each pair is crossed with a data read or a data write as the clearing access, and with the arming status read present or absent. This separates a clear that needs the read from one that fires on any access, and a read-triggered clear from a write-triggered one. Directed sequences cover three cases: a flag that rises between the read and the access, a set that coincides with a clear, and a colliding write that must leave the stored byte alone. The slave-select pin is swept over all eight combinations of enable, busy and software level, which tells idle forcing apart from plain following.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int STAT_W    = 8;
  localparam int DONE_BIT  = 7;
  localparam int WCOL_BIT  = 6;
  localparam int NSSEN_BIT = 0;

  localparam int NUM_FLAGS = 2;
  localparam int FLAG_DONE = 0;
  localparam int FLAG_WCOL = 1;

  localparam logic NSS_IDLE = 1'b1;
endpackage

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/spi_clear_arm.sv
module spi_clear_arm #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stat_rd_i,
  input  logic         data_acc_i,
  input  logic [N-1:0] flags_i,
  output logic [N-1:0] clr_o
);
  logic         arm_q;
  logic [N-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      snap_q <= '0;
    end else if (stat_rd_i) begin
      arm_q  <= |flags_i;
      snap_q <= flags_i;
    end else if (data_acc_i) begin
      arm_q  <= 1'b0;
      snap_q <= '0;
    end
  end

  assign clr_o = (arm_q && data_acc_i) ? snap_q : '0;
endmodule

// File: rtl/spi_data_hold.sv
module spi_data_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              load_o
);
  logic [DATA_W-1:0] data_q;
  logic              load_q;
  logic              take;

  assign take = wr_i && !busy_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= take;
      if (take) data_q <= wdata_i;
    end
  end

  assign data_o = data_q;
  assign load_o = load_q;
endmodule

// File: rtl/spi_nss_drive.sv
module spi_nss_drive import spi_flag_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic busy_i,
  input  logic sw_sel_i,
  output logic nss_o
);
  logic nss_d;
  logic nss_q;

  always_comb begin
    if (en_i && !busy_i) nss_d = NSS_IDLE;
    else                 nss_d = sw_sel_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) nss_q <= NSS_IDLE;
    else        nss_q <= nss_d;
  end

  assign nss_o = nss_q;
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl import spi_flag_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_done_i,
  input  logic              xfer_busy_i,
  input  logic              sw_sel_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic [STAT_W-1:0] stat_rdata_o,
  input  logic              data_rd_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  output logic [DATA_W-1:0] data_rdata_o,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              done_flag_o,
  output logic              wcol_flag_o,
  output logic              irq_o,
  output logic              nss_o
);
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 data_acc;
  logic                 nss_en_q;
  logic                 stat_wdata_unused;
  logic [DATA_W-1:0]    data_q;

  assign stat_wdata_unused = ^stat_wdata_i[STAT_W-1:1];

  assign data_acc            = data_rd_i || data_wr_i;
  assign flag_set[FLAG_DONE] = xfer_done_i;
  assign flag_set[FLAG_WCOL] = data_wr_i && xfer_busy_i;

  genvar g;
  generate
    for (g = 0; g < NUM_FLAGS; g++) begin : g_flag
      spi_sticky_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set[g]),
        .clr_i  (flag_clr[g]),
        .flag_o (flag_q[g])
      );
    end
  endgenerate

  spi_clear_arm #(.N(NUM_FLAGS)) u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_rd_i  (stat_rd_i),
    .data_acc_i (data_acc),
    .flags_i    (flag_q),
    .clr_o      (flag_clr)
  );

  spi_data_hold #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (data_wr_i),
    .busy_i  (xfer_busy_i),
    .wdata_i (data_wdata_i),
    .data_o  (data_q),
    .load_o  (tx_load_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         nss_en_q <= 1'b0;
    else if (stat_wr_i) nss_en_q <= stat_wdata_i[NSSEN_BIT];
  end

  spi_nss_drive u_nss (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (nss_en_q),
    .busy_i   (xfer_busy_i),
    .sw_sel_i (sw_sel_i),
    .nss_o    (nss_o)
  );

  always_comb begin
    stat_rdata_o            = '0;
    stat_rdata_o[DONE_BIT]  = flag_q[FLAG_DONE];
    stat_rdata_o[WCOL_BIT]  = flag_q[FLAG_WCOL];
    stat_rdata_o[NSSEN_BIT] = nss_en_q;
  end

  assign data_rdata_o = data_q;
  assign tx_byte_o    = data_q;
  assign done_flag_o  = flag_q[FLAG_DONE];
  assign wcol_flag_o  = flag_q[FLAG_WCOL];
  assign irq_o        = |flag_q;
endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_done_i,
  input logic              xfer_busy_i,
  input logic              sw_sel_i,
  input logic [7:0]        stat_rdata_o,
  input logic              data_rd_i,
  input logic              data_wr_i,
  input logic [DATA_W-1:0] data_wdata_i,
  input logic [DATA_W-1:0] data_rdata_o,
  input logic              tx_load_o,
  input logic              done_flag_o,
  input logic              wcol_flag_o,
  input logic              irq_o,
  input logic              nss_o
);
  assert_done_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_i |=> done_flag_o);

  assert_wcol_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_i && xfer_busy_i) |=> wcol_flag_o);

  assert_wcol_keeps_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_i && xfer_busy_i) |=> ($stable(data_rdata_o) && !tx_load_o));

  assert_idle_write_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_i && !xfer_busy_i) |=> (tx_load_o && data_rdata_o == $past(data_wdata_i)));

  assert_done_clear_by_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag_o) |-> $past(data_rd_i || data_wr_i));

  assert_wcol_clear_by_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wcol_flag_o) |-> $past(data_rd_i || data_wr_i));

  assert_irq_rise_has_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(xfer_done_i || (data_wr_i && xfer_busy_i)));

  assert_nss_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata_o[0] && !xfer_busy_i) |=> nss_o);

  assert_nss_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rdata_o[0] |=> (nss_o == $past(sw_sel_i)));
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/spi_flag_ctrl_tb_top.sv
module spi_flag_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          xfer_done, xfer_busy, sw_sel;
  logic          stat_rd, stat_wr;
  logic [7:0]    stat_wdata, stat_rdata;
  logic          data_rd, data_wr;
  logic [DW-1:0] data_wdata, data_rdata, tx_byte;
  logic          tx_load, done_f, wcol_f, irq, nss;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flag_ctrl #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_done_i(xfer_done), .xfer_busy_i(xfer_busy),
    .sw_sel_i(sw_sel), .stat_rd_i(stat_rd), .stat_wr_i(stat_wr),
    .stat_wdata_i(stat_wdata), .stat_rdata_o(stat_rdata), .data_rd_i(data_rd),
    .data_wr_i(data_wr), .data_wdata_i(data_wdata), .data_rdata_o(data_rdata),
    .tx_load_o(tx_load), .tx_byte_o(tx_byte), .done_flag_o(done_f),
    .wcol_flag_o(wcol_f), .irq_o(irq), .nss_o(nss)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_inputs();
    xfer_done = 0; xfer_busy = 0; sw_sel = 0;
    stat_rd = 0; stat_wr = 0; stat_wdata = 0;
    data_rd = 0; data_wr = 0; data_wdata = 0;
  endtask

  task automatic do_reset();
    clear_inputs();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic pulse_done();
    xfer_done = 1; tick(); xfer_done = 0;
  endtask

  task automatic collide(input logic [DW-1:0] b);
    xfer_busy = 1; data_wr = 1; data_wdata = b; tick();
    data_wr = 0; xfer_busy = 0;
  endtask

  task automatic stat_read();
    stat_rd = 1; tick(); stat_rd = 0;
  endtask

  function automatic logic [7:0] stat_exp(input logic d, input logic w, input logic en);
    return {d, w, 5'b0, en};
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 status", stat_rdata, 8'h00);
    check("R1 data", data_rdata, 0);
    check("R1 irq", irq, 0);
    check("R1 tx_load", tx_load, 0);
    check("R1 nss", nss, 1);

    // R2 only bit 0 writable
    stat_wr = 1; stat_wdata = 8'hFF; tick(); stat_wr = 0;
    check("R2 write FF", stat_rdata, 8'h01);
    stat_wr = 1; stat_wdata = 8'hFE; tick(); stat_wr = 0;
    check("R2 write FE", stat_rdata, 8'h00);

    // R3 completion
    pulse_done();
    check("R3 done", stat_rdata, stat_exp(1, 0, 0));
    check("R9 irq done", irq, 1);

    // R5 idle write, R4 collision
    do_reset();
    data_wr = 1; data_wdata = 8'h5A; tick(); data_wr = 0;
    check("R5 data", data_rdata, 8'h5A);
    check("R5 load", tx_load, 1);
    check("R5 tx_byte", tx_byte, 8'h5A);
    tick();
    check("R5 load one cycle", tx_load, 0);
    collide(8'hA5);
    check("R4 data kept", data_rdata, 8'h5A);
    check("R4 no load", tx_load, 0);
    check("R4 wcol", stat_rdata, stat_exp(0, 1, 0));
    check("R9 irq wcol", irq, 1);

    // R6 sweep: flags x access type x arming read
    for (int d = 0; d < 2; d++)
      for (int w = 0; w < 2; w++)
        for (int acc = 0; acc < 2; acc++)
          for (int pre = 0; pre < 2; pre++) begin
            logic ed, ew;
            do_reset();
            if (w != 0) collide(8'h11);
            if (d != 0) pulse_done();
            if (pre != 0) begin
              stat_rd = 1;
              check("R6 read value", stat_rdata, stat_exp(d[0], w[0], 0));
              tick(); stat_rd = 0;
            end
            if (acc != 0) begin data_wr = 1; data_wdata = 8'h3C + 8'(d*4 + w*2 + pre); end
            else data_rd = 1;
            tick(); data_wr = 0; data_rd = 0;
            ed = (pre != 0) ? 1'b0 : d[0];
            ew = (pre != 0) ? 1'b0 : w[0];
            check("R6 flags after access", stat_rdata, stat_exp(ed, ew, 0));
            check("R9 irq after access", irq, ed | ew);
            if (acc != 0) check("R5 write in sweep", data_rdata, 8'h3C + 8'(d*4 + w*2 + pre));
          end

    // R7 late flag not cleared, single-use arm
    do_reset();
    collide(8'h00);
    stat_read();
    pulse_done();
    data_rd = 1; tick(); data_rd = 0;
    check("R7 late done kept", stat_rdata, stat_exp(1, 0, 0));
    data_rd = 1; tick(); data_rd = 0;
    check("R7 disarmed", stat_rdata, stat_exp(1, 0, 0));

    // R8 set wins over clear
    do_reset();
    pulse_done();
    stat_read();
    data_rd = 1; xfer_done = 1; tick(); data_rd = 0; xfer_done = 0;
    check("R8 done set wins", done_f, 1);
    do_reset();
    pulse_done();
    stat_read();
    collide(8'h77);
    check("R8 clear done, set wcol", stat_rdata, stat_exp(0, 1, 0));

    // R10 / R11 slave-select sweep
    do_reset();
    for (int en = 0; en < 2; en++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 2; s++) begin
          logic exp_nss;
          stat_wr = 1; stat_wdata = 8'(en); tick(); stat_wr = 0;
          xfer_busy = b[0]; sw_sel = s[0]; tick();
          exp_nss = (en != 0 && b == 0) ? 1'b1 : s[0];
          check((en != 0) ? "R10 nss enabled" : "R11 nss follows", nss, exp_nss);
          xfer_busy = 0;
        end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule